// File: doc/BRIEF.md
# Command Mailbox with In-Band Completion Codes

This block is the device side of a command/response mailbox. A host first loads a subsystem selector and a few parameter words through a simple word-addressed register port. It then writes a command code into the low byte of the mailbox word. The block latches the code and clears the completion byte. It decodes the command, carries out the action, and writes any result words back into the parameter registers. One cycle later it writes a completion code into the upper byte of the mailbox word.

The implemented actions are three. A board-information query returns a fixed identifier and the channel count. A single read returns one word from a small per-subsystem register bank. A single write stores one word into that bank. Completion is reported in-band, and the host polls the mailbox word until the upper byte is non-zero. A command-done flag, visible both as a register bit and as a pin, sets on the same edge that the completion code appears.

Top module: `cmd_mailbox`

## Requirements
- R1: After reset, the mailbox word, the subsystem register, every parameter register, the flag register and the `cmd_done` pin are all zero.
- R2: Host word addresses are fixed. Address 0 is the mailbox word, with the command code in bits [7:0] and the completion code in bits [15:8]. Address 1 is the subsystem register, address 2 is the flag register, and address 3+i is parameter i. Writes to the subsystem and parameter registers while idle read back unchanged.
- R3: A mailbox write accepted while idle takes effect on the next edge. The code byte equals the written bits [7:0], the completion byte reads 0x00 whatever the host wrote in bits [15:8], and the done flag clears.
- R4: Result parameters are written on the second edge after the accepted command write. The completion code is written on the third edge, so it is never written on the same edge as the results.
- R5: The done flag is bit 7 of the flag register and is also driven on `cmd_done`. It sets on the same edge that the completion byte becomes non-zero. A flag-register write with bit 7 set clears the flag and leaves the mailbox word unchanged.
- R6: Command 6 (write single) takes the channel from parameter 0 and the data from parameter 2, and requires parameter 1 to be 0. It stores the data into bank cell (subsystem, channel) and completes with 0x55.
- R7: Command 5 (read single) takes the channel from parameter 0 and the gain from parameter 1. It places the bank cell (subsystem, channel) in parameter 2 and completes with 0x55.
- R8: A read or write single with subsystem above 5, channel at or above CHANS, gain at or above NGAIN (read) or non-zero parameter 1 (write) completes with 0xAA. It changes neither the parameters nor the bank.
- R9: Any command code other than 0, 5 and 6 completes with 0xFF and leaves all parameter registers unchanged.
- R10: Command 0 (board info) writes BOARD_ID into parameter 0 and CHANS into parameter 1 and completes with 0x55.
- R11: While a command is in progress, host writes to the mailbox, subsystem and parameter registers are ignored.
- R12: Each subsystem code 0 to 5 (0 analog in, 1 analog out, 2 digital in, 3 digital out, 4 memory, 5 counter/timer) owns a separate bank of CHANS cells.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one word per cycle |
| host_addr | input | AW | Host word address |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Read data for `host_addr` (combinational) |
| cmd_done | output | 1 | Command-done flag |

## Verification
The bench builds the block with DW=16, NPARAM=8, CHANS=4, NGAIN=4 and BOARD_ID=0x00A7. With four channels and four gains, the first illegal channel and gain (4) sit just above the last legal ones. These cases can be reached with small parameter values. At 16 bits, the mailbox word is exactly the code byte plus the status byte, so the bench can observe the cleared upper byte directly. The small bank also lets the bench write distinct values into different subsystems and channels, read them back and cover the separation between banks.

// File: rtl/cmd_mailbox_pkg.sv
package cmd_mailbox_pkg;
   localparam logic [7:0] ST_PENDING = 8'h00;
   localparam logic [7:0] ST_OK      = 8'h55;
   localparam logic [7:0] ST_FAIL    = 8'hAA;
   localparam logic [7:0] ST_UNSUP   = 8'hFF;

   localparam logic [7:0] OP_BOARD_INFO = 8'd0;
   localparam logic [7:0] OP_READ_ONE   = 8'd5;
   localparam logic [7:0] OP_WRITE_ONE  = 8'd6;

   localparam int NUM_SUBSYS = 6;

   localparam int A_MBX    = 0;
   localparam int A_SUBSYS = 1;
   localparam int A_FLAG   = 2;
   localparam int A_PRM0   = 3;
   localparam int DONE_BIT = 7;

   typedef enum logic [1:0] {PH_IDLE, PH_EXEC, PH_FIN} phase_t;
endpackage

// File: rtl/mbx_seq.sv
module mbx_seq
   import cmd_mailbox_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic in_exec,
   output logic in_fin
);
   phase_t ph_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph_q <= PH_IDLE;
      else begin
         unique case (ph_q)
            PH_IDLE: if (start) ph_q <= PH_EXEC;
            PH_EXEC: ph_q <= PH_FIN;
            default: ph_q <= PH_IDLE;
         endcase
      end
   end

   assign busy    = (ph_q != PH_IDLE);
   assign in_exec = (ph_q == PH_EXEC);
   assign in_fin  = (ph_q == PH_FIN);
endmodule

// File: rtl/mbx_bank.sv
module mbx_bank #(
   parameter int DW    = 16,
   parameter int NSUB  = 6,
   parameter int CHANS = 4,
   localparam int SW   = $clog2(NSUB),
   localparam int CW   = $clog2(CHANS),
   localparam int NCELL = NSUB * CHANS
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [SW-1:0] sel_sub,
   input  logic [CW-1:0] sel_ch,
   input  logic [DW-1:0] wr_data,
   output logic [DW-1:0] rd_data
);
   logic [DW-1:0] cell_rd [NCELL];

   for (genvar s = 0; s < NSUB; s++) begin : g_sub
      for (genvar c = 0; c < CHANS; c++) begin : g_ch
         logic [DW-1:0] cell_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cell_q <= '0;
            else if (wr_en && sel_sub == SW'(s) && sel_ch == CW'(c))
               cell_q <= wr_data;
         end
         assign cell_rd[s*CHANS + c] = cell_q;
      end
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NCELL; i++)
         if (int'(sel_sub) * CHANS + int'(sel_ch) == i && int'(sel_sub) < NSUB)
            rd_data = cell_rd[i];
   end
endmodule

// File: rtl/mbx_decode.sv
module mbx_decode
   import cmd_mailbox_pkg::*;
#(
   parameter int DW    = 16,
   parameter int CHANS = 4,
   parameter int NGAIN = 4,
   parameter int NSUB  = 6,
   parameter logic [DW-1:0] BOARD_ID = '0
) (
   input  logic [7:0]    op,
   input  logic [DW-1:0] subsys,
   input  logic [DW-1:0] p0,
   input  logic [DW-1:0] p1,
   input  logic [DW-1:0] bank_rd,
   output logic [7:0]    status,
   output logic [2:0]    res_we,
   output logic [DW-1:0] res_p0,
   output logic [DW-1:0] res_p1,
   output logic [DW-1:0] res_p2,
   output logic          bank_we
);
   localparam logic [DW-1:0] NSUB_W  = DW'(NSUB);
   localparam logic [DW-1:0] CHANS_W = DW'(CHANS);
   localparam logic [DW-1:0] NGAIN_W = DW'(NGAIN);

   logic sub_ok, ch_ok, gain_ok;

   assign sub_ok  = subsys < NSUB_W;
   assign ch_ok   = p0 < CHANS_W;
   assign gain_ok = p1 < NGAIN_W;

   always_comb begin
      status  = ST_UNSUP;
      res_we  = 3'b000;
      res_p0  = BOARD_ID;
      res_p1  = CHANS_W;
      res_p2  = bank_rd;
      bank_we = 1'b0;
      unique case (op)
         OP_BOARD_INFO: begin
            status = ST_OK;
            res_we = 3'b011;
         end
         OP_READ_ONE: begin
            if (sub_ok && ch_ok && gain_ok) begin
               status = ST_OK;
               res_we = 3'b100;
            end else status = ST_FAIL;
         end
         OP_WRITE_ONE: begin
            if (sub_ok && ch_ok && p1 == '0) begin
               status  = ST_OK;
               bank_we = 1'b1;
            end else status = ST_FAIL;
         end
         default: status = ST_UNSUP;
      endcase
   end
endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
   import cmd_mailbox_pkg::*;
#(
   parameter int DW     = 16,
   parameter int NPARAM = 8,
   parameter int CHANS  = 4,
   parameter int NGAIN  = 4,
   parameter logic [DW-1:0] BOARD_ID = 16'h00A7,
   localparam int AW = $clog2(A_PRM0 + NPARAM),
   localparam int SW = $clog2(NUM_SUBSYS),
   localparam int CW = $clog2(CHANS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          host_wr,
   input  logic [AW-1:0] host_addr,
   input  logic [DW-1:0] host_wdata,
   output logic [DW-1:0] host_rdata,
   output logic          cmd_done
);
   if (DW < 16) begin : g_bad_dw
      $error("cmd_mailbox: DW must be at least 16");
   end
   if (NPARAM < 3) begin : g_bad_np
      $error("cmd_mailbox: NPARAM must be at least 3");
   end
   if (CHANS < 2) begin : g_bad_ch
      $error("cmd_mailbox: CHANS must be at least 2");
   end
   if (NGAIN < 1) begin : g_bad_gn
      $error("cmd_mailbox: NGAIN must be at least 1");
   end

   logic          busy, in_exec, in_fin, start;
   logic [7:0]    op_q, stat_q, hold_q, dec_status;
   logic          flag_q;
   logic [DW-1:0] subsys_q;
   logic [DW-1:0] prm_arr [NPARAM];
   logic [NPARAM*DW-1:0] prm_flat;
   logic [2:0]    res_we;
   logic [DW-1:0] res_p0, res_p1, res_p2, bank_rd;
   logic          bank_we, host_ok;

   assign host_ok = host_wr && !busy;
   assign start   = host_ok && host_addr == AW'(A_MBX);

   mbx_seq u_seq (
      .clk(clk), .rst_n(rst_n), .start(start),
      .busy(busy), .in_exec(in_exec), .in_fin(in_fin)
   );

   mbx_decode #(
      .DW(DW), .CHANS(CHANS), .NGAIN(NGAIN), .NSUB(NUM_SUBSYS), .BOARD_ID(BOARD_ID)
   ) u_dec (
      .op(op_q), .subsys(subsys_q), .p0(prm_arr[0]), .p1(prm_arr[1]),
      .bank_rd(bank_rd), .status(dec_status), .res_we(res_we),
      .res_p0(res_p0), .res_p1(res_p1), .res_p2(res_p2), .bank_we(bank_we)
   );

   mbx_bank #(.DW(DW), .NSUB(NUM_SUBSYS), .CHANS(CHANS)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(in_exec && bank_we),
      .sel_sub(subsys_q[SW-1:0]), .sel_ch(prm_arr[0][CW-1:0]),
      .wr_data(prm_arr[2]), .rd_data(bank_rd)
   );

   // Parameter registers: the first three also take command results.
   for (genvar g = 0; g < NPARAM; g++) begin : g_prm
      logic [DW-1:0] q;
      if (g < 3) begin : g_res
         logic [DW-1:0] rv;
         assign rv = (g == 0) ? res_p0 : (g == 1) ? res_p1 : res_p2;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else if (host_ok && host_addr == AW'(A_PRM0 + g)) q <= host_wdata;
            else if (in_exec && res_we[g]) q <= rv;
         end
      end else begin : g_plain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else if (host_ok && host_addr == AW'(A_PRM0 + g)) q <= host_wdata;
         end
      end
      assign prm_arr[g] = q;
      assign prm_flat[g*DW +: DW] = q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) subsys_q <= '0;
      else if (host_ok && host_addr == AW'(A_SUBSYS)) subsys_q <= host_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q   <= '0;
         stat_q <= ST_PENDING;
         hold_q <= ST_PENDING;
      end else if (start) begin
         op_q   <= host_wdata[7:0];
         stat_q <= ST_PENDING;
      end else if (in_exec) begin
         hold_q <= dec_status;
      end else if (in_fin) begin
         stat_q <= hold_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else if (in_fin) flag_q <= 1'b1;
      else if (start) flag_q <= 1'b0;
      else if (host_wr && host_addr == AW'(A_FLAG) && host_wdata[DONE_BIT])
         flag_q <= 1'b0;
   end

   assign cmd_done = flag_q;

   always_comb begin
      host_rdata = '0;
      if (host_addr == AW'(A_MBX))         host_rdata = DW'({stat_q, op_q});
      else if (host_addr == AW'(A_SUBSYS)) host_rdata = subsys_q;
      else if (host_addr == AW'(A_FLAG))   host_rdata[DONE_BIT] = flag_q;
      else begin
         for (int i = 0; i < NPARAM; i++)
            if (host_addr == AW'(A_PRM0 + i)) host_rdata = prm_arr[i];
      end
   end
endmodule

// File: rtl/cmd_mailbox_chk.sv
module cmd_mailbox_chk #(
   parameter int DW     = 16,
   parameter int NPARAM = 8,
   parameter int AW     = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 host_wr,
   input logic [AW-1:0]        host_addr,
   input logic                 busy,
   input logic [7:0]           stat,
   input logic                 flag,
   input logic [DW-1:0]        subsys,
   input logic [NPARAM*DW-1:0] prm_flat
);
   // R3: an accepted command write clears status and flag on the next edge
   p_clear_on_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && host_addr == '0 && !busy) |=> (stat == 8'h00 && !flag));

   // R5: the flag sets together with the status
   p_flag_with_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(stat) == 8'h00 && stat != 8'h00) |-> flag);

   // R5: the flag never rises without the status rising
   p_flag_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> (stat != 8'h00 && $past(stat) == 8'h00));

   // R4: results are already in place when the status appears
   p_status_after_results_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(stat) == 8'h00 && stat != 8'h00) |-> $stable(prm_flat));

   // R9: unsupported commands leave every parameter as it was
   p_unsup_keeps_params_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(stat) == 8'h00 && stat == 8'hFF) |-> prm_flat == $past(prm_flat, 2));

   // R11: subsystem register holds through a command
   p_busy_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(subsys));

   // R3: only the four completion codes ever appear
   p_status_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (stat == 8'h00 || stat == 8'h55 || stat == 8'hAA || stat == 8'hFF));
endmodule

bind cmd_mailbox cmd_mailbox_chk #(.DW(DW), .NPARAM(NPARAM), .AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
   .busy(busy), .stat(stat_q), .flag(flag_q), .subsys(subsys_q),
   .prm_flat(prm_flat)
);

// File: tb/cmd_mailbox_tb_top.sv
module cmd_mailbox_tb_top;
   localparam int DW = 16;
   localparam int AW = 4;
   localparam logic [3:0] MBX = 0, SUB = 1, FLG = 2, P0 = 3, P1 = 4, P2 = 5;

   logic clk = 0, rst_n = 0, host_wr = 0, rd_valid = 0;
   logic [AW-1:0] host_addr = '0;
   logic [DW-1:0] host_wdata = '0, host_rdata;
   logic cmd_done;
   int total = 0, fails = 0;

   typedef struct { logic [DW-1:0] exp; string tag; } exp_t;
   exp_t sb_q[$];

   always #5 clk = ~clk;

   cmd_mailbox #(.DW(16), .NPARAM(8), .CHANS(4), .NGAIN(4), .BOARD_ID(16'h00A7)) dut_i (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .cmd_done(cmd_done)
   );

   // Monitor: compares each scheduled read against the scoreboard
   always @(posedge clk) begin
      if (rd_valid) begin
         exp_t it;
         it = sb_q.pop_front();
         total++;
         if (host_rdata !== it.exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", it.tag, host_rdata, it.exp);
         end
      end
   end

   task automatic rd_now(input logic [3:0] a, input logic [DW-1:0] e, input string tag);
      exp_t it;
      it.exp = e; it.tag = tag;
      sb_q.push_back(it);
      host_addr = a; rd_valid = 1;
      @(posedge clk); #1 rd_valid = 0;
   endtask

   task automatic do_read(input logic [3:0] a, input logic [DW-1:0] e, input string tag);
      @(negedge clk);
      rd_now(a, e, tag);
   endtask

   task automatic chk_pin(input logic act, input logic e, input string tag);
      total++;
      if (act !== e) begin
         fails++;
         $display("FAIL %s: got %b expected %b", tag, act, e);
      end
   endtask

   task automatic host_write(input logic [3:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      host_addr = a; host_wdata = d; host_wr = 1;
      @(posedge clk); #1 host_wr = 0;
   endtask

   task automatic run_cmd(input logic [7:0] op);
      host_write(MBX, {8'hC3, op});
      repeat (2) @(posedge clk);
      #1;
   endtask

   task automatic load(input logic [DW-1:0] s, input logic [DW-1:0] a0,
                       input logic [DW-1:0] a1, input logic [DW-1:0] a2);
      host_write(SUB, s); host_write(P0, a0); host_write(P1, a1); host_write(P2, a2);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      total++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      do_read(MBX, 16'h0000, "R1 mailbox");
      do_read(FLG, 16'h0000, "R1 flag");
      do_read(P2, 16'h0000, "R1 param2");
      chk_pin(cmd_done, 1'b0, "R1 cmd_done");

      // R2 register map readback
      host_write(SUB, 16'h0003); host_write(P0 + 4, 16'h1234);
      do_read(SUB, 16'h0003, "R2 subsystem");
      do_read(P0 + 4, 16'h1234, "R2 param4");

      // R10 board info with R3/R4 timing
      host_write(MBX, 16'hFF00);
      @(negedge clk);
      chk_pin(cmd_done, 1'b0, "R3 flag cleared");
      rd_now(MBX, 16'h0000, "R3 status cleared");
      @(negedge clk);
      chk_pin(cmd_done, 1'b0, "R4 no status with results");
      rd_now(P0, 16'h00A7, "R10 board id");
      do_read(MBX, 16'h5500, "R4 status third edge");
      do_read(P1, 16'h0004, "R10 channel count");
      do_read(FLG, 16'h0080, "R5 flag bit7");
      chk_pin(cmd_done, 1'b1, "R5 cmd_done set");

      // R5 flag clear
      host_write(FLG, 16'h0080);
      do_read(FLG, 16'h0000, "R5 flag cleared");
      do_read(MBX, 16'h5500, "R5 status kept");

      // R6 / R12 write single into two subsystems
      load(16'd1, 16'd2, 16'd0, 16'hBEEF); run_cmd(8'd6);
      do_read(MBX, 16'h5506, "R6 write ok");
      load(16'd3, 16'd2, 16'd0, 16'h1111); run_cmd(8'd6);
      do_read(MBX, 16'h5506, "R6 write ok subsys3");

      // R7 read single, gain at limit
      load(16'd1, 16'd2, 16'd3, 16'h0000); run_cmd(8'd5);
      do_read(MBX, 16'h5505, "R7 read ok");
      do_read(P2, 16'hBEEF, "R7 read data");
      load(16'd3, 16'd2, 16'd0, 16'h0000); run_cmd(8'd5);
      do_read(P2, 16'h1111, "R12 separate bank");
      load(16'd1, 16'd3, 16'd0, 16'h5A5A); run_cmd(8'd5);
      do_read(P2, 16'h0000, "R7 last channel");
      load(16'd5, 16'd0, 16'd0, 16'h5A5A); run_cmd(8'd5);
      do_read(MBX, 16'h5505, "R12 subsystem 5 valid");

      // R8 error cases
      load(16'd1, 16'd4, 16'd0, 16'h7777); run_cmd(8'd6);
      do_read(MBX, 16'hAA06, "R8 channel out of range");
      load(16'd1, 16'd2, 16'd1, 16'h7777); run_cmd(8'd6);
      do_read(MBX, 16'hAA06, "R8 nonzero param1 write");
      load(16'd1, 16'd2, 16'd4, 16'h3C3C); run_cmd(8'd5);
      do_read(MBX, 16'hAA05, "R8 gain out of range");
      do_read(P2, 16'h3C3C, "R8 param2 unchanged");
      load(16'd6, 16'd2, 16'd0, 16'h3C3C); run_cmd(8'd5);
      do_read(MBX, 16'hAA05, "R8 subsystem 6");
      load(16'd1, 16'd2, 16'd0, 16'h0000); run_cmd(8'd5);
      do_read(P2, 16'hBEEF, "R8 bank untouched by failed writes");

      // R9 unsupported codes
      load(16'd0, 16'h0101, 16'h0202, 16'h0303); run_cmd(8'd3);
      do_read(MBX, 16'hFF03, "R9 code 3");
      do_read(P0, 16'h0101, "R9 param0 kept");
      run_cmd(8'd48);
      do_read(MBX, 16'hFF30, "R9 code 48");
      chk_pin(cmd_done, 1'b1, "R5 flag on unsupported");
      run_cmd(8'hC8);
      do_read(MBX, 16'hFFC8, "R9 code 200");
      do_read(P2, 16'h0303, "R9 param2 kept");

      // R11 writes ignored while busy
      load(16'd0, 16'd1, 16'd0, 16'hABCD);
      host_write(MBX, 16'h0006);
      host_write(P0, 16'd2);
      host_write(MBX, 16'h0005);
      do_read(P0, 16'h0001, "R11 param0 ignored");
      do_read(MBX, 16'h5506, "R11 mailbox ignored");
      load(16'd0, 16'd1, 16'd0, 16'h0000); run_cmd(8'd5);
      do_read(P2, 16'hABCD, "R11 write went to channel 1");
      load(16'd0, 16'd2, 16'd0, 16'h0000); run_cmd(8'd5);
      do_read(P2, 16'h0000, "R11 channel 2 untouched");

      repeat (2) @(negedge clk);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule